// File: doc/BRIEF.md
# Receive Frame Qualifier for Nibble and Byte PHY Interfaces

This block sits between the receive side of a PHY interface and the receive buffer of a MAC. It takes either 4-bit data at 10/100 Mbps or 8-bit data at gigabit rate, selected by a mode input. In 4-bit mode it packs nibbles into bytes. It finds the start and end of each frame from the data-valid input. It then passes a byte stream downstream with first-beat and last-beat markers.

While a frame is in progress, the block records any receive error, any collision seen in half-duplex operation, an odd trailing nibble, and an overrun of a programmable length limit. At the last beat it gives one verdict: commit, pass-as-bad, or drop. The verdict depends on a control bit that lets bad frames through for sniffer-style capture. If the receive buffer has already stored bytes of a frame that is then dropped, it rewinds them. Single-cycle pulses feed the error and drop counters. A synchronized copy of carrier sense drives activity LEDs.

Top module: `rxq_frame_qual`

## Requirements
- R1: While reset is held, and in the first cycle after it, all data, marker, status and pulse outputs are 0.
- R2: With `gmii_sel`=1, each cycle with `rx_valid`=1 carries one byte on `rx_data[7:0]`. The bytes come out in arrival order. `o_sof` marks the first beat. `o_eof` marks the last beat, which appears in the cycle after the first low sample of `rx_valid`. No other beat carries `o_eof`.
- R3: With `gmii_sel`=0, only `rx_data[3:0]` is used. The first nibble of each pair is the low half of a byte, and one byte is formed from every two valid nibbles.
- R4: In 4-bit mode, a frame that ends with an unpaired nibble is bad. The lone nibble is not output.
- R5: On the `o_eof` beat exactly one of `o_good`, `o_bad` and `o_drop` is 1. On every other cycle all three are 0, and so are both pulse outputs. A frame is good when it is non-empty and has no error, no counted collision, no truncation and no odd nibble. A frame with no whole byte is output as a single beat of data 0 with both markers set, and it is bad.
- R6: If `rx_err`=1 in any cycle with `rx_valid`=1, the frame is bad and `o_err_pulse` is 1 for that frame's `o_eof` beat only.
- R7: A bad frame ends with `o_drop`=1 and `o_drop_pulse`=1 when `pass_bad`=0. When `pass_bad`=1 it ends with `o_bad`=1 and no drop pulse.
- R8: If `col_in`=1 during reception while `full_dup`=0, the frame is bad. When `full_dup`=1, `col_in` has no effect on the verdict.
- R9: At most `max_len` bytes of a frame are output. A longer frame is cut at that length and is bad.
- R10: `o_activity` follows `crs_in` with a delay of SYNC_STAGES clock edges.
- R11: The interface width is taken from `gmii_sel` in the first valid cycle of a frame. A change of `gmii_sel` later in the same frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gmii_sel | input | 1 | 1 = byte interface, 0 = nibble interface |
| rx_valid | input | 1 | Receive data valid |
| rx_err | input | 1 | Receive error from PHY |
| rx_data | input | 8 | Receive data (bits 3:0 only in nibble mode) |
| col_in | input | 1 | Collision indication |
| full_dup | input | 1 | 1 = full duplex, collisions ignored |
| pass_bad | input | 1 | Pass bad frames flagged instead of dropping |
| max_len | input | LEN_W | Maximum bytes output per frame |
| crs_in | input | 1 | Carrier sense, asynchronous |
| o_valid | output | 1 | Output byte strobe |
| o_data | output | 8 | Output byte |
| o_sof | output | 1 | First beat of frame |
| o_eof | output | 1 | Last beat of frame, status valid |
| o_good | output | 1 | Frame committed |
| o_bad | output | 1 | Frame bad but passed |
| o_drop | output | 1 | Frame to be discarded |
| o_err_pulse | output | 1 | Receive-error counter increment |
| o_drop_pulse | output | 1 | Drop counter increment |
| o_activity | output | 1 | Synchronized carrier sense |

## Verification
Each whole byte is held for one beat, so it leaves the block on the clock edge that accepts the next byte. The last byte leaves on the edge that first samples `rx_valid` low, and the verdict and pulses come out on that same beat. The bench drives inputs on falling edges and samples the outputs on the next falling edge, before it drives again. It gathers the beats seen during a frame. It then requires `o_eof` on exactly the sample after the one where it dropped `rx_valid`, and on no earlier sample. `o_activity` is checked as 0 at one sample after `crs_in` changes and as 1 at the sample after that, which matches the two-stage default.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned NIB_W  = 4;
   localparam int unsigned BYTE_W = 2 * NIB_W;

   typedef struct packed {
      logic              valid;
      logic [BYTE_W-1:0] data;
      logic              sof;
      logic              eof;
      logic              good;
      logic              bad;
      logic              drop;
      logic              err_p;
      logic              drop_p;
   } rxq_beat_t;
endpackage

// File: rtl/rxq_nib_pack.sv
module rxq_nib_pack
   import rxq_pkg::*;
#(
   parameter bit SUPPORT_NIB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv,
   input  logic              sof,
   input  logic              mode_in,
   input  logic [BYTE_W-1:0] din,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_o,
   output logic              half_o
);
   generate
      if (SUPPORT_NIB) begin : g_nib
         logic             mode_q;
         logic             half_q;
         logic [NIB_W-1:0] lo_q;
         logic             eff_byte;

         // width choice is frozen at the first valid cycle of a frame
         assign eff_byte = sof ? mode_in : mode_q;
         assign half_o   = half_q;

         always_comb begin
            byte_stb = 1'b0;
            byte_o   = din;
            if (dv) begin
               if (eff_byte) begin
                  byte_stb = 1'b1;
               end else if (half_q) begin
                  byte_stb = 1'b1;
                  byte_o   = {din[NIB_W-1:0], lo_q};
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mode_q <= 1'b1;
               half_q <= 1'b0;
               lo_q   <= '0;
            end else begin
               if (sof) mode_q <= mode_in;
               if (!dv) begin
                  half_q <= 1'b0;
               end else if (!eff_byte) begin
                  half_q <= !half_q;
                  if (!half_q) lo_q <= din[NIB_W-1:0];
               end
            end
         end
      end else begin : g_byte_only
         assign byte_stb = dv;
         assign byte_o   = din;
         assign half_o   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rxq_crs_sync.sv
module rxq_crs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rxq_frame_track.sv
module rxq_frame_track
   import rxq_pkg::*;
#(
   parameter int unsigned LEN_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv,
   input  logic              sof,
   input  logic              eof,
   input  logic              byte_stb,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              odd_nib,
   input  logic              rx_err,
   input  logic              col_in,
   input  logic              full_dup,
   input  logic              pass_bad,
   input  logic [LEN_W-1:0]  max_len,
   output rxq_beat_t         beat
);
   logic              er_f, col_f, trunc_f;
   logic [LEN_W-1:0]  cnt;
   logic              pend_v, pend_first;
   logic [BYTE_W-1:0] pend_d;

   logic              er_n, col_n, trunc_n;
   logic [LEN_W-1:0]  cnt_base;
   logic              room, accept, bad;

   always_comb begin
      cnt_base = sof ? '0 : cnt;
      room     = cnt_base < max_len;
      accept   = byte_stb && room;
      er_n     = (sof ? 1'b0 : er_f)    | (dv & rx_err);
      col_n    = (sof ? 1'b0 : col_f)   | (dv & col_in & !full_dup);
      trunc_n  = (sof ? 1'b0 : trunc_f) | (byte_stb & !room);
      bad      = er_f | col_f | trunc_f | odd_nib | (cnt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         er_f       <= 1'b0;
         col_f      <= 1'b0;
         trunc_f    <= 1'b0;
         cnt        <= '0;
         pend_v     <= 1'b0;
         pend_first <= 1'b0;
         pend_d     <= '0;
         beat       <= '0;
      end else begin
         beat    <= '0;
         er_f    <= er_n;
         col_f   <= col_n;
         trunc_f <= trunc_n;
         cnt     <= cnt_base + LEN_W'(accept);
         if (accept) begin
            if (pend_v) begin
               beat.valid <= 1'b1;
               beat.data  <= pend_d;
               beat.sof   <= pend_first;
            end
            pend_v     <= 1'b1;
            pend_d     <= byte_i;
            pend_first <= (cnt_base == '0);
         end
         if (eof) begin
            beat.valid  <= 1'b1;
            beat.data   <= pend_v ? pend_d : '0;
            beat.sof    <= pend_v ? pend_first : 1'b1;
            beat.eof    <= 1'b1;
            beat.good   <= !bad;
            beat.bad    <= bad & pass_bad;
            beat.drop   <= bad & !pass_bad;
            beat.err_p  <= er_f;
            beat.drop_p <= bad & !pass_bad;
            pend_v      <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rxq_frame_qual.sv
module rxq_frame_qual
   import rxq_pkg::*;
#(
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SUPPORT_NIB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gmii_sel,
   input  logic             rx_valid,
   input  logic             rx_err,
   input  logic [7:0]       rx_data,
   input  logic             col_in,
   input  logic             full_dup,
   input  logic             pass_bad,
   input  logic [LEN_W-1:0] max_len,
   input  logic             crs_in,
   output logic             o_valid,
   output logic [7:0]       o_data,
   output logic             o_sof,
   output logic             o_eof,
   output logic             o_good,
   output logic             o_bad,
   output logic             o_drop,
   output logic             o_err_pulse,
   output logic             o_drop_pulse,
   output logic             o_activity
);
   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LEN_W < 2) begin : g_chk_len
         $error("LEN_W must be at least 2");
      end
      if (BYTE_W != 8) begin : g_chk_byte
         $error("output byte must be 8 bits");
      end
   endgenerate

   logic              dv_q, sof, eof;
   logic              byte_stb, half;
   logic [BYTE_W-1:0] byte_w;
   rxq_beat_t         beat;

   always_ff @(posedge clk) begin
      if (!rst_n) dv_q <= 1'b0;
      else        dv_q <= rx_valid;
   end

   assign sof = rx_valid & !dv_q;
   assign eof = !rx_valid & dv_q;

   rxq_nib_pack #(.SUPPORT_NIB(SUPPORT_NIB)) u_pack (
      .clk(clk), .rst_n(rst_n), .dv(rx_valid), .sof(sof),
      .mode_in(gmii_sel), .din(rx_data),
      .byte_stb(byte_stb), .byte_o(byte_w), .half_o(half)
   );

   rxq_frame_track #(.LEN_W(LEN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .dv(rx_valid), .sof(sof), .eof(eof),
      .byte_stb(byte_stb), .byte_i(byte_w), .odd_nib(eof & half),
      .rx_err(rx_err), .col_in(col_in), .full_dup(full_dup),
      .pass_bad(pass_bad), .max_len(max_len), .beat(beat)
   );

   rxq_crs_sync #(.STAGES(SYNC_STAGES)) u_crs (
      .clk(clk), .rst_n(rst_n), .d(crs_in), .q(o_activity)
   );

   assign o_valid      = beat.valid;
   assign o_data       = beat.data;
   assign o_sof        = beat.sof;
   assign o_eof        = beat.eof;
   assign o_good       = beat.good;
   assign o_bad        = beat.bad;
   assign o_drop       = beat.drop;
   assign o_err_pulse  = beat.err_p;
   assign o_drop_pulse = beat.drop_p;
endmodule

// File: rtl/rxq_frame_qual_chk.sv
module rxq_frame_qual_chk #(
   parameter int unsigned LEN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pass_bad,
   input logic [LEN_W-1:0] max_len,
   input logic             o_valid,
   input logic             o_sof,
   input logic             o_eof,
   input logic             o_good,
   input logic             o_bad,
   input logic             o_drop,
   input logic             o_err_pulse,
   input logic             o_drop_pulse
);
   logic [LEN_W-1:0] beats_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) beats_seen <= '0;
      else if (o_valid) beats_seen <= o_eof ? '0 : beats_seen + 1'b1;
   end

   // R5
   verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_eof |-> $countones({o_good, o_bad, o_drop}) == 1);

   // R5
   quiet_midframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !o_eof |-> $countones({o_good, o_bad, o_drop, o_err_pulse, o_drop_pulse}) == 0);

   // R2
   last_is_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_eof || o_sof) |-> o_valid);

   // R7
   pass_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_eof && $past(pass_bad)) |-> !o_drop && !o_drop_pulse);

   // R7
   drop_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_drop |-> o_drop_pulse);

   // R9
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (beats_seen < max_len) || (beats_seen == '0));
endmodule

bind rxq_frame_qual rxq_frame_qual_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pass_bad(pass_bad), .max_len(max_len),
   .o_valid(o_valid), .o_sof(o_sof), .o_eof(o_eof), .o_good(o_good),
   .o_bad(o_bad), .o_drop(o_drop), .o_err_pulse(o_err_pulse),
   .o_drop_pulse(o_drop_pulse)
);

// File: tb/rxq_frame_qual_tb.sv
module rxq_frame_qual_tb;
   localparam int LW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          gmii_sel = 1'b1, rx_valid = 1'b0, rx_err = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          col_in = 1'b0, full_dup = 1'b0, pass_bad = 1'b0, crs_in = 1'b0;
   logic [LW-1:0] max_len = LW'(64);
   logic          o_valid, o_sof, o_eof, o_good, o_bad, o_drop;
   logic          o_err_pulse, o_drop_pulse, o_activity;
   logic [7:0]    o_data;

   int n_chk = 0, n_bad = 0;

   always #10 clk = !clk;

   rxq_frame_qual u_dut (
      .clk(clk), .rst_n(rst_n), .gmii_sel(gmii_sel), .rx_valid(rx_valid),
      .rx_err(rx_err), .rx_data(rx_data), .col_in(col_in), .full_dup(full_dup),
      .pass_bad(pass_bad), .max_len(max_len), .crs_in(crs_in),
      .o_valid(o_valid), .o_data(o_data), .o_sof(o_sof), .o_eof(o_eof),
      .o_good(o_good), .o_bad(o_bad), .o_drop(o_drop),
      .o_err_pulse(o_err_pulse), .o_drop_pulse(o_drop_pulse),
      .o_activity(o_activity)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   logic [7:0] got_d[$];
   bit         got_s[$];
   bit         early;
   int         st_g, st_b, st_d, st_e, st_p, st_eof;

   task automatic sample(input bit last);
      if (o_valid) begin
         got_d.push_back(o_data);
         got_s.push_back(o_sof);
      end
      if (o_eof && !last) early = 1'b1;
      if (last) begin
         st_eof = o_eof; st_g = o_good; st_b = o_bad; st_d = o_drop;
         st_e = o_err_pulse; st_p = o_drop_pulse;
      end
   endtask

   function automatic logic [7:0] pat(input int nb, input int i);
      return 8'((nb * 29 + i * 13 + 7) & 255);
   endfunction

   // one frame; mii=1 nibble mode; er_at/col_at are beat indices (-1 none)
   task automatic frame(input bit mii, input int nb, input bit odd, input int er_at,
                        input int col_at, input bit fdx, input bit allow,
                        input int maxl, input bit flip, input string tag);
      int  nbeats, emit, nexp;
      bit  er_hit, col_hit, bad, ok;
      got_d.delete(); got_s.delete(); early = 1'b0;
      nbeats = mii ? 2 * nb + int'(odd) : nb;
      @(negedge clk);
      sample(1'b0);
      gmii_sel = !mii; full_dup = fdx; pass_bad = allow; max_len = LW'(maxl);
      for (int j = 0; j < nbeats; j++) begin
         if (j > 0) begin @(negedge clk); sample(1'b0); end
         rx_valid = 1'b1;
         rx_err   = (j == er_at);
         col_in   = (j == col_at);
         if (mii) begin
            if (j / 2 >= nb) rx_data = 8'hA5;
            else rx_data = {4'hC, (j % 2 == 0) ? pat(nb, j/2)[3:0] : pat(nb, j/2)[7:4]};
            if (flip && j == 1) gmii_sel = 1'b1;
         end else begin
            rx_data = pat(nb, j);
         end
      end
      @(negedge clk); sample(1'b0);
      rx_valid = 1'b0; rx_err = 1'b0; col_in = 1'b0; gmii_sel = 1'b1;
      @(negedge clk); sample(1'b1);
      er_hit  = (er_at >= 0) && (er_at < nbeats);
      col_hit = (col_at >= 0) && (col_at < nbeats) && !fdx;
      emit    = (nb < maxl) ? nb : maxl;
      bad     = er_hit || col_hit || (mii && odd) || (nb > maxl) || (emit == 0);
      nexp    = (emit == 0) ? 1 : emit;
      // R2: last beat due exactly one sample after valid drops
      check({tag, " R2 eof timing"}, {31'd0, st_eof} | (early ? 2 : 0), 1);
      check({tag, " beat count"}, got_d.size(), nexp);
      ok = 1'b1;
      for (int i = 0; i < got_d.size() && i < nexp; i++) begin
         if (got_d[i] != ((emit == 0) ? 8'h00 : pat(nb, i))) ok = 1'b0;
         if (got_s[i] != (i == 0)) ok = 1'b0;
      end
      check({tag, mii ? " R3 packed data" : " R2 byte data"}, int'(ok), 1);
      // R5 verdict, R7 pass/drop
      check({tag, " R5/R7 verdict gbd"}, {st_g[0], st_b[0], st_d[0]},
            {!bad, bad && allow, bad && !allow});
      check({tag, " R6/R7 pulses ed"}, {st_e[0], st_p[0]}, {er_hit, bad && !allow});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset outs", {o_valid, o_sof, o_eof, o_good, o_bad, o_drop,
            o_err_pulse, o_drop_pulse, o_activity}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {o_valid, o_eof, o_good, o_drop, o_activity}, 0);

      // R10 carrier sense sync (2 stages)
      crs_in = 1'b1;
      @(negedge clk); check("R10 act stage1", o_activity, 0);
      @(negedge clk); check("R10 act rise", o_activity, 1);
      crs_in = 1'b0;
      @(negedge clk); check("R10 act hold", o_activity, 1);
      @(negedge clk); check("R10 act fall", o_activity, 0);

      for (int m = 0; m < 2; m++) begin
         for (int nb = 0; nb <= 5; nb++) begin
            for (int sc = 0; sc < 6; sc++) begin
               for (int al = 0; al < 2; al++) begin
                  bit mii, odd;
                  int nbeats;
                  mii = (m == 0);
                  odd = (sc == 5) || (nb == 0);
                  if (!mii && (nb == 0 || sc == 5)) continue;
                  nbeats = mii ? 2 * nb + int'(odd) : nb;
                  case (sc)
                     0: frame(mii, nb, odd, -1, -1, 0, al[0], 64, mii && nb >= 2, "R11 clean");
                     1: frame(mii, nb, odd, nbeats / 2, -1, 0, al[0], 64, 0, "R6 rxerr");
                     2: frame(mii, nb, odd, -1, nbeats - 1, 0, al[0], 64, 0, "R8 col half");
                     3: frame(mii, nb, odd, -1, 0, 1, al[0], 64, 0, "R8 col full");
                     4: frame(mii, nb, odd, -1, -1, 0, al[0], 2, 0, "R9 maxlen");
                     default: frame(mii, nb, odd, -1, -1, 0, al[0], 64, 0, "R4 odd nibble");
                  endcase
               end
            end
         end
      end
      // R9 boundary: exactly max_len bytes is not truncated
      frame(1'b0, 4, 1'b0, -1, -1, 0, 1'b0, 4, 1'b0, "R9 equal len");
      frame(1'b1, 3, 1'b0, -1, -1, 0, 1'b1, 3, 1'b0, "R9 equal len mii");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule